// File: doc/BRIEF.md
# Chip-Select Gated Memory Command Register

This block is the clocked command and address stage that sits between a memory controller and the DRAM devices on a registered module. On each rising clock edge it captures a word of address and command bits together with a clock-enable bit, an on-die-termination bit and a chip-select bit. The captured values drive the module's DRAM devices for the next cycle. Two active-low chip selects gate the data word. While both are high, the data outputs hold their previous contents. The clock-enable, termination and chip-select paths are not gated and are captured on every edge.

Two static configuration pins set the output layout. In the full-width layout, 25 data bits each drive one output. In the split layout, 14 bits are registered and each one drives a pair of identical copies, A and B. The control outputs are duplicated in the same way. A second pin selects which input group feeds the split layout. The one illegal pin combination behaves as the full-width layout. An active-low reset acts asynchronously, takes priority over all other inputs and drives every output low. The configuration pins are changed only while reset is asserted.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: In full-width mode (`mode_split`=0, `map_upper`=0), if `cs_n_in` or `csr_n_in` is low at a rising edge, `q_a` shows the `d_in` value sampled at that edge.
- R2: If `cs_n_in` and `csr_n_in` are both high at a rising edge, `q_a` and `q_b` keep their values.
- R3: While `rst_n` is low, every output is low. This takes effect without a clock edge and overrides the chip selects.
- R4: `q_cke_a`, `q_odt_a` and `q_cs_n_a` show `cke_in`, `odt_in` and `cs_n_in` from the previous rising edge, whatever the chip selects are.
- R5: In split mode (`mode_split`=1), `q_b` and `q_a[13:0]` carry the same 14 registered bits, and `q_a[24:14]` is low.
- R6: In split mode, `map_upper`=0 takes the 14 bits from `d_in[13:0]`, and `map_upper`=1 takes them from `d_in[24:11]`.
- R7: `map_upper`=1 with `mode_split`=0 behaves exactly like full-width mode.
- R8: In split mode, `q_cke_b`, `q_odt_b` and `q_cs_n_b` equal their A copies. In full-width mode, these B copies and `q_b` are low.
- R9: With `csr_n_in` held low, the data outputs load on every edge, and `cs_n_in` acts only as a registered bit on `q_cs_n_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_split | input | 1 | 0: 25-bit single copy, 1: 14-bit dual copy |
| map_upper | input | 1 | Selects the input group in split mode |
| d_in | input | 25 | Address and command data |
| cke_in | input | 1 | Clock-enable bit |
| odt_in | input | 1 | Termination-control bit |
| cs_n_in | input | 1 | Primary chip select, active low |
| csr_n_in | input | 1 | Secondary chip select, active low |
| q_a | output | 25 | Data outputs, A copy or full width |
| q_b | output | 14 | Data outputs, B copy |
| q_cke_a | output | 1 | Registered clock enable, A |
| q_cke_b | output | 1 | Registered clock enable, B |
| q_odt_a | output | 1 | Registered termination, A |
| q_odt_b | output | 1 | Registered termination, B |
| q_cs_n_a | output | 1 | Registered chip select, A |
| q_cs_n_b | output | 1 | Registered chip select, B |

## Verification
The hardest case is a reset that lands between clock edges while the outputs are holding stale data under a deasserted chip select. Here the asynchronous clear has to win over the hold path. To reach it, the stimulus first loads random data and then forces both chip selects high for several cycles. It then drops reset a few nanoseconds after a falling edge and inspects the outputs before the next rising edge. This sequence is repeated in each of the four pin settings. A behavioural model tracks the expected outputs on every cycle.

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg #(
  parameter int W_FULL = 25,
  parameter int W_HALF = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_split,
  input  logic              map_upper,
  input  logic [W_FULL-1:0] d_in,
  input  logic              cke_in,
  input  logic              odt_in,
  input  logic              cs_n_in,
  input  logic              csr_n_in,
  output logic [W_FULL-1:0] q_a,
  output logic [W_HALF-1:0] q_b,
  output logic              q_cke_a,
  output logic              q_cke_b,
  output logic              q_odt_a,
  output logic              q_odt_b,
  output logic              q_cs_n_a,
  output logic              q_cs_n_b
);
  localparam int PAD      = W_FULL - W_HALF;
  localparam int UPPER_LO = W_FULL - W_HALF;

  logic [W_FULL-1:0] data_r;
  logic              cke_r, odt_r, cs_r;
  logic              load, split, upper;
  logic [W_HALF-1:0] half_sel;

  assign load  = !cs_n_in || !csr_n_in;
  assign split = mode_split;
  assign upper = mode_split & map_upper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r <= '0;
      cke_r  <= 1'b0;
      odt_r  <= 1'b0;
      cs_r   <= 1'b0;
    end else begin
      cke_r <= cke_in;
      odt_r <= odt_in;
      cs_r  <= cs_n_in;
      if (load) data_r <= d_in;
    end
  end

  assign half_sel = upper ? data_r[W_FULL-1:UPPER_LO] : data_r[W_HALF-1:0];
  assign q_a      = split ? {{PAD{1'b0}}, half_sel} : data_r;
  assign q_b      = split ? half_sel : '0;
  assign q_cke_a  = cke_r;
  assign q_odt_a  = odt_r;
  assign q_cs_n_a = cs_r;
  assign q_cke_b  = split & cke_r;
  assign q_odt_b  = split & odt_r;
  assign q_cs_n_b = split & cs_r;

  assert_load_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !mode_split) |=> (q_a == $past(d_in)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_in && csr_n_in) |=> ($stable(q_a) && $stable(q_b)));

  assert_reset_low_R3: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0 && !q_cke_a && !q_cke_b &&
                !q_odt_a && !q_odt_b && !q_cs_n_a && !q_cs_n_b));

  assert_ctrl_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_cke_a == $past(cke_in) && q_odt_a == $past(odt_in) &&
              q_cs_n_a == $past(cs_n_in)));

  assert_split_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_split |-> (q_a[W_HALF-1:0] == q_b && q_a[W_FULL-1:W_HALF] == '0));

  assert_upper_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_split && map_upper && load) |=> (q_b == $past(d_in[W_FULL-1:UPPER_LO])));

  assert_b_copies_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_split ? (q_cke_b == q_cke_a && q_odt_b == q_odt_a && q_cs_n_b == q_cs_n_a)
               : (q_b == '0 && !q_cke_b && !q_odt_b && !q_cs_n_b));
endmodule

// File: tb/cs_gated_cmd_reg_bench.sv
`timescale 1ns/1ps
module cs_gated_cmd_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic c1 = 1'b0, c0 = 1'b0;
  logic [24:0] d = '0;
  logic cke = 0, odt = 0, csn = 1, csrn = 1;
  logic [24:0] q_a;
  logic [13:0] q_b;
  logic cka, ckb, oda, odb, csa, csb;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cs_gated_cmd_reg u_cs_gated_cmd_reg (
    .clk(clk), .rst_n(rst_n), .mode_split(c1), .map_upper(c0), .d_in(d),
    .cke_in(cke), .odt_in(odt), .cs_n_in(csn), .csr_n_in(csrn),
    .q_a(q_a), .q_b(q_b), .q_cke_a(cka), .q_cke_b(ckb), .q_odt_a(oda),
    .q_odt_b(odb), .q_cs_n_a(csa), .q_cs_n_b(csb));

  // behavioural reference
  logic [24:0] m_data;
  logic m_cke, m_odt, m_cs;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0; m_cke = 0; m_odt = 0; m_cs = 0;
    end else begin
      m_cke = cke; m_odt = odt; m_cs = csn;
      if (csn == 1'b0 || csrn == 1'b0) m_data = d;
    end
  end

  task automatic cmp(string td, string tc);
    logic [13:0] sel;
    logic [24:0] ea;
    logic [13:0] eb;
    logic [5:0] ec, ac;
    sel = (c1 && c0) ? m_data[24:11] : m_data[13:0];
    ea  = c1 ? {11'b0, sel} : m_data;
    eb  = c1 ? sel : 14'b0;
    ec  = {m_cke, c1 & m_cke, m_odt, c1 & m_odt, m_cs, c1 & m_cs};
    ac  = {cka, ckb, oda, odb, csa, csb};
    checks++;
    if (q_a !== ea || q_b !== eb) begin
      failures++;
      $display("FAIL %s data q_a=%h q_b=%h expected q_a=%h q_b=%h", td, q_a, q_b, ea, eb);
    end
    checks++;
    if (ac !== ec) begin
      failures++;
      $display("FAIL %s control=%b expected %b", tc, ac, ec);
    end
  endtask

  // mode 0: random selects, 1: both high, 2: csr low
  task automatic run(int n, int mode, string td, string tc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(td, tc);
      d   = 25'($urandom);
      cke = 1'($urandom);
      odt = 1'($urandom);
      case (mode)
        0: begin csn = 1'($urandom); csrn = 1'($urandom); end
        1: begin csn = 1'b1; csrn = 1'b1; end
        default: begin csn = 1'($urandom); csrn = 1'b0; end
      endcase
    end
  endtask

  task automatic mid_reset();
    @(negedge clk);
    cmp("R2", "R4");
    #3 rst_n = 1'b0;
    #1;
    checks++;
    if (q_a !== '0 || q_b !== '0 || {cka, ckb, oda, odb, csa, csb} !== 6'b0) begin
      failures++;
      $display("FAIL R3 async reset q_a=%h q_b=%h ctl=%b expected all zero",
               q_a, q_b, {cka, ckb, oda, odb, csa, csb});
    end
    cmp("R3", "R3");
    @(negedge clk);
    cmp("R3", "R3");
    rst_n = 1'b1;
  endtask

  initial begin
    string tdata;
    #2 rst_n = 1'b0;
    for (int cfg = 0; cfg < 4; cfg++) begin
      rst_n = 1'b0;
      c1 = cfg[1]; c0 = cfg[0];
      tdata = !c1 ? (c0 ? "R7" : "R1") : (c0 ? "R6" : "R5");
      @(negedge clk);
      @(negedge clk);
      cmp("R3", "R3");
      rst_n = 1'b1;
      run(60, 0, tdata, c1 ? "R8" : "R4");
      run(15, 1, "R2", "R4");
      run(30, 2, "R9", "R9");
      run(30, 0, tdata, "R8");
      run(10, 1, "R2", "R4");
      mid_reset();
      run(40, 0, tdata, "R4");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule